// File: doc/BRIEF.md
# Flash Command Interface Controller

This block stands between a simple synchronous microcontroller bus and a small word-wide flash array that is modelled in registers. Software never writes the array directly. It issues short command sequences, and the controller turns them into timed program, sector erase and bulk erase operations. Each operation lasts for a parameterised number of clock cycles. While an operation runs, ordinary reads return an embedded-algorithm status byte instead of array data. This lets software poll for completion without any extra register.

The controller also offers four further features:
- an unlock bypass mode that shortens repeated programming;
- suspend and resume for a sector erase;
- a query that reports whether a sector is protected;
- a per-sector protect input.

A ready output is low whenever an operation owns the array. An active-low asynchronous reset abandons any operation in progress.

The array holds 2^AW bytes, split into NSEC equal sectors. The sector number is formed by the top bits of the address.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While rst_n is low, ready is 1 and rdata is 00h, whatever operation was running. An operation cut short by reset leaves the array unchanged, and the controller then accepts commands in read mode.
- R2: The program command is the writes AAh, 55h, A0h, each at an even address, followed by one write of the target address and data. From the edge that samples that final write, ready is low for exactly PROG_CYC cycles. Afterwards, a read of the target returns the data.
- R3: A read while a program runs returns the inverse of bit 7 of the data being programmed in bit 7. During an erase, bit 7 reads 0. Bits 4..0 of any status read are 0.
- R4: Each read taken while ready is low inverts bit 6 relative to the previous such read. Once the operation ends, reads return stable array data.
- R5: A program that would turn any stored 0 bit into 1 fails. Ready stays low, and status reads show bit 5 set, bit 7 as in R3 and bit 6 toggling. The array is left unchanged. A write of F0h returns the controller to read mode.
- R6: The writes AAh, 55h, 80h, AAh, 55h, each at an even address, followed by 30h at an even address inside a sector, erase that sector to FFh. Ending the same sequence with 10h instead erases every unprotected sector. Either way, ready is low for ERASE_CYC cycles.
- R7: For EWIN_CYC cycles after a sector erase starts, the following rules apply. A further 30h write adds its sector to the erase and restarts both the window and the erase count. A B0h write suspends the erase. Any other write abandons the erase: ready rises on the next cycle and the array is unchanged.
- R8: A B0h write during a sector erase keeps ready low for SUSP_LAT more cycles, then raises it. While suspended, reads return unchanged array data and the erase makes no progress, however long the suspension lasts.
- R9: A 30h write resumes a suspended erase, which then finishes after its remaining count. A 30h write in read mode starts nothing and ready stays 1.
- R10: A program or erase aimed at a sector whose protect bit is 1 leaves that sector unchanged and keeps ready at 1. A bulk erase skips protected sectors.
- R11: The writes AAh, 55h, 90h followed by a read return 01h if the sector of the read address is protected, and 00h if it is not.
- R12: The writes AAh, 55h, 20h enter bypass mode. In bypass mode, A0h followed by an address/data write programs that word as in R2 and then returns to bypass mode, and other writes are ignored. The pair 90h, 00h, at any address, leaves bypass mode. After that, a lone A0h no longer programs.
- R13: A command write at an odd address, or with data that does not continue a valid sequence, returns the controller to read mode without effect.
- R14: If a B0h write is sampled on the same edge at which the erase count expires, the suspend wins and the sector is not erased until a resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| we | input | 1 | Bus write strobe, one cycle per write |
| re | input | 1 | Bus read strobe, one cycle per read |
| addr | input | AW | Word address |
| wdata | input | 8 | Write data or command byte |
| protect | input | NSEC | Per-sector write protection |
| rdata | output | 8 | Read result, registered on the read edge |
| ready | output | 1 | Low while an operation owns the array |

## Verification
Two functions can land on the same clock edge: expiry of the erase count, and a suspend command from the bus. The bench times a B0h write to be sampled exactly on the edge where a sector erase would complete. It then judges that the suspend took priority: ready must stay low for the suspend latency, the sector must still read its old data, and the resume must finish after a single cycle. A similar clash is provoked inside the erase window. There, a foreign write and a sector-adding 30h write each compete with the running count, and the result is judged by the ready length and the surviving array contents.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW        = 6,
  parameter int NSEC      = 4,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20,
  parameter int EWIN_CYC  = 5,
  parameter int SUSP_LAT  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            re,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  input  logic [NSEC-1:0] protect,
  output logic [7:0]      rdata,
  output logic            ready
);
  localparam int SW    = $clog2(NSEC);
  localparam int SHIFT = AW - SW;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(ERASE_CYC + PROG_CYC + EWIN_CYC + SUSP_LAT + 1);

  typedef enum logic [3:0] {
    S_RD, S_U1, S_U2, S_PA, S_E1, S_E2, S_E3, S_QRY,
    S_BYP, S_BPA, S_BX, S_PROG, S_ERS, S_SUSW, S_SUSP, S_ERR
  } st_t;

  st_t             st;
  logic [CW-1:0]   cnt, wcnt;
  logic [AW-1:0]   pa;
  logic [7:0]      pd;
  logic            fail, bulk, ret_byp, tog;
  logic [NSEC-1:0] emask;
  logic [7:0]      mem [DEPTH];

  wire [SW-1:0]   wsec      = addr[AW-1 -: SW];
  wire [NSEC-1:0] soh       = NSEC'(1) << wsec;
  wire            even      = ~addr[0];
  wire            busy      = (st == S_PROG) || (st == S_ERS) || (st == S_SUSW) || (st == S_ERR);
  wire            ers_cmd   = we && ((!bulk && wdata == 8'hB0) || wcnt != '0);
  wire            prog_done = (st == S_PROG) && cnt == '0 && !fail && !protect[pa[AW-1 -: SW]];
  wire            ers_done  = (st == S_ERS) && cnt == '0 && !ers_cmd;
  wire            susp      = (st == S_SUSP);
  wire [7:0]      stat      = {(st == S_PROG || st == S_ERR) ? ~pd[7] : 1'b0, tog, st == S_ERR, 5'b0};

  assign ready = !busy;

  always_ff @(posedge clk) begin
    if (prog_done) mem[pa] <= pd;
    for (int i = 0; i < DEPTH; i++)
      if (ers_done && emask[SW'(i >> SHIFT)] && !protect[SW'(i >> SHIFT)]) mem[AW'(i)] <= 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RD;
      cnt     <= '0;
      wcnt    <= '0;
      pa      <= '0;
      pd      <= '0;
      fail    <= 1'b0;
      bulk    <= 1'b0;
      ret_byp <= 1'b0;
      tog     <= 1'b0;
      emask   <= '0;
      rdata   <= '0;
    end else begin
      if (re && busy) tog <= ~tog;
      if (re) rdata <= busy ? stat : (st == S_QRY) ? {7'b0, protect[wsec]} : mem[addr];
      case (st)
        S_RD:  if (we) st <= (even && wdata == 8'hAA) ? S_U1 : S_RD;
        S_U1:  if (we) st <= (even && wdata == 8'h55) ? S_U2 : S_RD;
        S_U2:  if (we) begin
          if (!even) st <= S_RD;
          else case (wdata)
            8'hA0:   st <= S_PA;
            8'h80:   st <= S_E1;
            8'h90:   st <= S_QRY;
            8'h20:   st <= S_BYP;
            default: st <= S_RD;
          endcase
        end
        S_PA, S_BPA: if (we) begin
          if (protect[wsec]) st <= (st == S_BPA) ? S_BYP : S_RD;
          else begin
            pa      <= addr;
            pd      <= wdata;
            fail    <= |(wdata & ~mem[addr]);
            cnt     <= CW'(PROG_CYC - 1);
            ret_byp <= (st == S_BPA);
            st      <= S_PROG;
          end
        end
        S_E1:  if (we) st <= (even && wdata == 8'hAA) ? S_E2 : S_RD;
        S_E2:  if (we) st <= (even && wdata == 8'h55) ? S_E3 : S_RD;
        S_E3:  if (we) begin
          if (even && wdata == 8'h30 && !protect[wsec]) begin
            emask <= soh;
            bulk  <= 1'b0;
            wcnt  <= CW'(EWIN_CYC - 1);
            cnt   <= CW'(ERASE_CYC - 1);
            st    <= S_ERS;
          end else if (even && wdata == 8'h10 && protect != '1) begin
            emask <= ~protect;
            bulk  <= 1'b1;
            wcnt  <= '0;
            cnt   <= CW'(ERASE_CYC - 1);
            st    <= S_ERS;
          end else st <= S_RD;
        end
        S_QRY: if (re || we) st <= S_RD;
        S_BYP: if (we) begin
          if (wdata == 8'hA0) st <= S_BPA;
          else if (wdata == 8'h90) st <= S_BX;
        end
        S_BX:  if (we) st <= (wdata == 8'h00) ? S_RD : S_BYP;
        S_PROG:
          if (cnt == '0) st <= fail ? S_ERR : (ret_byp ? S_BYP : S_RD);
          else cnt <= cnt - 1'b1;
        S_ERS:
          if (we && !bulk && wdata == 8'hB0) begin
            st   <= S_SUSW;
            wcnt <= CW'(SUSP_LAT - 1);
          end else if (ers_cmd) begin
            if (wdata == 8'h30 && even) begin
              if (!protect[wsec]) emask <= emask | soh;
              wcnt <= CW'(EWIN_CYC - 1);
              cnt  <= CW'(ERASE_CYC - 1);
            end else st <= S_RD;
          end else begin
            if (wcnt != '0) wcnt <= wcnt - 1'b1;
            if (cnt == '0) st <= S_RD;
            else cnt <= cnt - 1'b1;
          end
        S_SUSW:
          if (wcnt == '0) st <= S_SUSP;
          else wcnt <= wcnt - 1'b1;
        S_SUSP: if (we && wdata == 8'h30) st <= S_ERS;
        S_ERR:  if (we && wdata == 8'hF0) st <= S_RD;
        default: st <= S_RD;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int AW   = 6,
  parameter int NSEC = 4,
  parameter int CW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            re,
  input logic            ready,
  input logic [7:0]      rdata,
  input logic [NSEC-1:0] protect,
  input logic            susp,
  input logic [CW-1:0]   cnt,
  input logic [7:0]      mem [1 << AW]
);
  localparam int SHIFT = AW - $clog2(NSEC);

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    re && !ready && $past(re && !ready) |=> rdata[6] != $past(rdata[6]));

  p_status_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    re && !ready |=> rdata[4:0] == 5'b0);

  p_susp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    susp && $past(susp) |-> $stable(cnt));

  for (genvar i = 0; i < (1 << AW); i++) begin : g_word
    p_prot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(protect[i >> SHIFT]) |-> mem[i] == $past(mem[i]));
  end
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW), .NSEC(NSEC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .re(re), .ready(ready), .rdata(rdata),
  .protect(protect), .susp(susp), .cnt(cnt), .mem(mem)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 20;
  localparam int EWIN_CYC  = 5;
  localparam int SUSP_LAT  = 3;

  logic       clk = 0, rst_n = 0, we = 0, re = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] protect = '0;
  wire  [7:0] rdata;
  wire        ready;
  logic [7:0] model [64];
  int nv = 0, nf = 0;

  flash_cmd_ctrl #(.AW(6), .NSEC(4), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                   .EWIN_CYC(EWIN_CYC), .SUSP_LAT(SUSP_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr), .wdata(wdata),
    .protect(protect), .rdata(rdata), .ready(ready));

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  endtask

  task automatic chk(string r, int act, int exp);
    nv++;
    if (act != exp) begin
      nf++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    we = 1; addr = 6'(a); wdata = 8'(d);
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    re = 1; addr = 6'(a);
    @(negedge clk);
    re = 0;
    d = rdata;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic unlock(); wr(0, 'hAA); wr(0, 'h55); endtask
  task automatic prog(int a, int d); unlock(); wr(0, 'hA0); wr(a, d); endtask
  task automatic serase(int a); unlock(); wr(0, 'h80); unlock(); wr(a, 'h30); endtask
  task automatic berase(); unlock(); wr(0, 'h80); unlock(); wr(0, 'h10); endtask

  task automatic progw(string r, int a, int d);
    int n;
    prog(a, d); wait_rdy(n);
    chk(r, n, PROG_CYC);
    model[a] = 8'(d);
  endtask

  task automatic erase_model(int s);
    for (int i = 0; i < 16; i++) model[s*16+i] = 8'hFF;
  endtask

  task automatic checkall(string r);
    logic [7:0] v;
    for (int i = 0; i < 64; i++) begin rd(i, v); chk(r, v, model[i]); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nf++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    logic [7:0] v1, v2, d;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", ready, 1);
    chk("R1 rdata in reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);

    berase(); wait_rdy(n);
    chk("R6 bulk length", n, ERASE_CYC);
    for (int s = 0; s < 4; s++) erase_model(s);
    checkall("R6 bulk fill");

    for (int i = 0; i < 64; i++) begin
      d = 8'((i * 37 + 5) & 255);
      prog(i, d);
      if (i % 8 == 0) begin
        rd(i, v1); rd(i, v2);
        chk("R3 poll bit", v1[7], !d[7]);
        chk("R3 low bits", v1[4:0], 0);
        chk("R4 toggle", v1[6] ^ v2[6], 1);
        wait_rdy(n);
        rd(i, v1); rd(i, v2);
        chk("R4 stable after", v1, d);
        chk("R4 stable after", v2, d);
      end else begin
        wait_rdy(n);
        chk("R2 busy length", n, PROG_CYC);
      end
      model[i] = d;
    end
    checkall("R2 program sweep");

    prog(5, 'hFF);
    repeat (PROG_CYC + 2) @(negedge clk);
    chk("R5 busy on fail", ready, 0);
    rd(5, v1); rd(5, v2);
    chk("R5 error bit", v1[5], 1);
    chk("R5 poll bit", v1[7], 0);
    chk("R5 toggle", v1[6] ^ v2[6], 1);
    wr(0, 'hF0);
    chk("R5 F0 exit", ready, 1);
    rd(5, v1);
    chk("R5 array kept", v1, model[5]);

    for (int p = 0; p < 16; p++) begin
      protect = 4'(p);
      for (int s = 0; s < 4; s++) begin
        unlock(); wr(0, 'h90); rd(s * 16 + 2, v1);
        chk("R11 query", v1, (p >> s) & 1);
      end
    end

    protect = 4'b0010;
    prog(16, 0);
    chk("R10 prog ignored", ready, 1);
    rd(16, v1); chk("R10 prog ignored", v1, model[16]);
    serase(16);
    chk("R10 erase ignored", ready, 1);
    rd(16, v1); chk("R10 erase ignored", v1, model[16]);
    berase(); wait_rdy(n);
    chk("R10 bulk length", n, ERASE_CYC);
    erase_model(0); erase_model(2); erase_model(3);
    checkall("R10 bulk skip");
    protect = '0;

    progw("R2 setup", 0, 'h11);
    progw("R2 setup", 32, 'h3C);
    progw("R2 setup", 40, 'h5A);
    progw("R2 setup", 48, 'h77);

    serase(32);
    @(negedge clk); @(negedge clk);
    wr(0, 'h55);
    chk("R7 abort ready", ready, 1);
    rd(32, v1); chk("R7 abort keeps", v1, 'h3C);
    rd(40, v1); chk("R7 abort keeps", v1, 'h5A);

    serase(32);
    wr(0, 'h30);
    wait_rdy(n);
    chk("R7 add restarts", n, ERASE_CYC);
    erase_model(0); erase_model(2);
    checkall("R7 two sectors");

    serase(48);
    repeat (8) @(negedge clk);
    wr(0, 'hB0);
    wait_rdy(n);
    chk("R8 suspend latency", n, SUSP_LAT);
    rd(48, v1); rd(48, v2);
    chk("R8 suspended data", v1, 'h77);
    chk("R8 suspended data", v2, 'h77);
    repeat (30) @(negedge clk);
    chk("R8 stays suspended", ready, 1);
    rd(48, v1); chk("R8 no progress", v1, 'h77);
    wr(0, 'h30);
    wait_rdy(n);
    chk("R9 resume remaining", n, ERASE_CYC - 8);
    erase_model(3);
    rd(48, v1); chk("R9 resumed erase", v1, 'hFF);

    wr(0, 'h30);
    chk("R9 resume in read mode", ready, 1);
    rd(16, v1); chk("R9 resume in read mode", v1, model[16]);

    progw("R14 setup", 16, 'h41);
    serase(16);
    repeat (ERASE_CYC - 1) @(negedge clk);
    chk("R14 still busy", ready, 0);
    wr(0, 'hB0);
    wait_rdy(n);
    chk("R14 suspend wins", n, SUSP_LAT);
    rd(16, v1); chk("R14 not erased", v1, 'h41);
    wr(0, 'h30);
    wait_rdy(n);
    chk("R14 resume one cycle", n, 1);
    erase_model(1);
    rd(16, v1); chk("R14 erased", v1, 'hFF);
    rd(31, v1); chk("R14 erased", v1, 'hFF);

    unlock(); wr(0, 'h20);
    for (int j = 0; j < 4; j++) begin
      wr(0, 'hA0); wr(33 + j, 'h10 + j); wait_rdy(n);
      chk("R12 bypass program", n, PROG_CYC);
      model[33 + j] = 8'('h10 + j);
    end
    wr(0, 'h55);
    wr(0, 'hA0); wr(37, 'h2C); wait_rdy(n);
    chk("R12 stray write ignored", n, PROG_CYC);
    model[37] = 8'h2C;
    for (int j = 33; j < 38; j++) begin rd(j, v1); chk("R12 bypass data", v1, model[j]); end
    wr(6, 'h90); wr(7, 'h00);
    wr(0, 'hA0); wr(50, 'h12);
    chk("R12 exited", ready, 1);
    rd(50, v1); chk("R12 exited", v1, 'hFF);

    wr(1, 'hAA); wr(0, 'h55); wr(0, 'hA0); wr(51, 'h00);
    chk("R13 odd address", ready, 1);
    rd(51, v1); chk("R13 odd address", v1, 'hFF);
    unlock(); wr(0, 'h77); wr(0, 'hA0); wr(52, 'h00);
    chk("R13 bad command", ready, 1);
    rd(52, v1); chk("R13 bad command", v1, 'hFF);
    progw("R13 recovers", 53, 'h0F);
    rd(53, v1); chk("R13 recovers", v1, 'h0F);

    prog(54, 'h00);
    @(negedge clk); @(negedge clk);
    chk("R1 busy before reset", ready, 0);
    rst_n = 0;
    @(negedge clk);
    chk("R1 ready in reset", ready, 1);
    chk("R1 rdata in reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    rd(54, v1); chk("R1 program aborted", v1, 'hFF);
    serase(48);
    repeat (5) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 erase aborted", ready, 1);
    rd(53, v1); chk("R1 erase aborted", v1, 'h0F);
    checkall("R1 final array");

    finish_run();
  end
endmodule